// File: doc/BRIEF.md
# Two-Stage PCI Target Address Decoder

This block sits behind a PCI target interface and decides, for each incoming target address, whether the device should claim the access and which memory or device region it goes to. The first stage compares the address against two groups of base windows. The plain group forwards data unchanged. The swap group tells the datapath to reverse the byte order of each 32-bit word. Enable bits for the memory space and the IO space gate both groups.

When a window hits, a second stage checks the address against inclusive low/high boundaries for each region. Only the regions that the winning window is allowed to reach are considered. A single window can therefore span several regions, such as two DRAM banks, and the sub-decode picks the bank.

If the window hits but no region matches, nothing is forwarded. A read yields undefined data and a write is dropped. A sticky miss interrupt is raised, which software clears by writing 1 to it. Configuration is written through a simple address/data write port. Each request produces one registered result one cycle later.

Top module: `pci_tgt_decode`

## Requirements
- R1: A window hits when it is enabled (attribute bit 0), its space bit (attribute bit 1: 1 = IO, 0 = memory) equals the request's space, and the request address equals the window base in every bit where the window mask is 1.
- R2: A hit is claimed only if the request's space is enabled in the command register at address 0x00: bit 1 enables memory space and bit 0 enables IO space. Otherwise the result shows no claim and no forward.
- R3: Plain windows occupy flat indices 0..NBAR-1 and swap windows occupy NBAR..2*NBAR-1. When several windows hit, the lowest index wins, so plain windows take priority. The swap flag is 1 exactly when a swap window wins.
- R4: A claimed request selects the lowest-indexed region r that meets two conditions: bit r of the winning window's region map (attribute bits [8+r]) is set, and low(r) <= address <= high(r).
- R5: When the swap flag is set, output data byte i equals input byte 3-i and output byte enable i equals input enable 3-i. Otherwise data and enables pass through unchanged.
- R6: A claimed request with no region match reports sub-hit 0 and forward 0, so the access never reaches memory. The forward output is 1 only for a claimed request with a region match.
- R7: A claimed request with no region match sets the miss interrupt in the same cycle its result appears. The interrupt then stays set until it is cleared. An unclaimed request never sets it.
- R8: Writing the cause address 0x01 with data bit 1 = 1 clears the interrupt, and writing it with bit 1 = 0 leaves it unchanged. A new miss in the same cycle as a clear takes priority and keeps the interrupt set.
- R9: Each request accepted with req_valid produces exactly one result with o_valid high on the next clock edge, and o_valid is low otherwise.
- R10: After reset, all windows are disabled, all registers read zero, no result is valid and the interrupt is clear.
- R11: Window k has its base at 0x10+(k/NBAR)*16+(k%NBAR)*4, its mask at base+1 and its attributes at base+2. Region r has its low bound at 0x80+2r and its high bound at 0x81+2r. A write takes effect on the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Target request present this cycle |
| req_addr | input | AW | Target address |
| req_is_io | input | 1 | 1 = IO space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables of the word |
| req_wdata | input | 32 | Write data word |
| o_valid | output | 1 | Result valid |
| o_claim | output | 1 | Device claims the access |
| o_swap | output | 1 | Datapath must reverse byte order |
| o_sub_hit | output | 1 | A region matched |
| o_region | output | RIDX_W | Index of the selected region |
| o_fwd | output | 1 | Access is forwarded to the region |
| o_write | output | 1 | Registered write flag |
| o_be | output | 4 | Byte enables after optional swap |
| o_data | output | 32 | Data after optional swap |
| o_miss_irq | output | 1 | Sticky region-miss interrupt |

## Verification
The assertions check the following on every cycle:
- the one-cycle result timing;
- that forwarding requires both a claim and a region match;
- that a swap result comes only from a claim;
- the byte and enable reversal against the previous cycle's inputs;
- that the interrupt rises only together with a claimed miss and stays set until a clear write.

Only the bench scenarios can show the decode outcomes themselves:
- window matching under mask, space and enable;
- plain-over-swap priority;
- region selection through the map and overlapping bounds;
- the effect of the command enables;
- set-over-clear priority on the interrupt.

// File: rtl/pci_tgt_decode_pkg.sv
// Shared constants and helpers for the PCI target address decoder.
// Assumes a 32-bit configuration data word and 32-bit data lanes.
package pci_tgt_decode_pkg;

    localparam int          CFG_AW        = 8;
    localparam int          CFG_DW        = 32;
    localparam logic [7:0]  CMD_ADDR      = 8'h00;
    localparam logic [7:0]  CAUSE_ADDR    = 8'h01;
    localparam logic [7:0]  WIN_BASE_ADDR = 8'h10;
    localparam logic [7:0]  RGN_BASE_ADDR = 8'h80;
    localparam int          MISS_BIT      = 1;
    localparam int          MAP_LSB       = 8;

    // Reverse the four bytes of a data word.
    function automatic logic [31:0] flip_word(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Reverse the byte enables the same way as the data bytes.
    function automatic logic [3:0] flip_be(input logic [3:0] be);
        return {be[0], be[1], be[2], be[3]};
    endfunction

endpackage

// File: rtl/ptd_cfg_regs.sv
// Configuration storage for the decoder: command enables, sticky miss
// cause, per-window base/mask/attributes and per-region bounds.
// Assumes AW <= 32, NBAR <= 4 and NREG <= 24 so the address map and the
// attribute word hold every field.
module ptd_cfg_regs
    import pci_tgt_decode_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NBAR = 2,
    parameter int NREG = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [CFG_DW-1:0]              cfg_wdata,
    input  logic                           miss_set,
    output logic                           io_en,
    output logic                           mem_en,
    output logic                           miss_irq,
    output logic [2*NBAR-1:0][AW-1:0]      win_base,
    output logic [2*NBAR-1:0][AW-1:0]      win_mask,
    output logic [2*NBAR-1:0]              win_en,
    output logic [2*NBAR-1:0]              win_io,
    output logic [2*NBAR-1:0][NREG-1:0]    win_map,
    output logic [NREG-1:0][AW-1:0]        rgn_lo,
    output logic [NREG-1:0][AW-1:0]        rgn_hi
);

    localparam int NWIN = 2 * NBAR;

    logic clr_hit;
    assign clr_hit = cfg_we && (cfg_addr == CAUSE_ADDR) && cfg_wdata[MISS_BIT];

    // Command register: space enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_en  <= 1'b0;
            mem_en <= 1'b0;
        end else if (cfg_we && cfg_addr == CMD_ADDR) begin
            io_en  <= cfg_wdata[0];
            mem_en <= cfg_wdata[1];
        end
    end

    // Sticky miss cause: a new miss wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        miss_irq <= 1'b0;
        else if (miss_set) miss_irq <= 1'b1;
        else if (clr_hit)  miss_irq <= 1'b0;
    end

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        localparam logic [7:0] A = WIN_BASE_ADDR + 8'(((k / NBAR) * 16) + ((k % NBAR) * 4));
        logic [AW-1:0]   base_q, mask_q;
        logic            en_q, io_q;
        logic [NREG-1:0] map_q;

        // Per-window base, mask and attribute registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                mask_q <= '0;
                en_q   <= 1'b0;
                io_q   <= 1'b0;
                map_q  <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == A)        base_q <= cfg_wdata[AW-1:0];
                if (cfg_addr == A + 8'd1) mask_q <= cfg_wdata[AW-1:0];
                if (cfg_addr == A + 8'd2) begin
                    en_q  <= cfg_wdata[0];
                    io_q  <= cfg_wdata[1];
                    map_q <= cfg_wdata[MAP_LSB +: NREG];
                end
            end
        end

        assign win_base[k] = base_q;
        assign win_mask[k] = mask_q;
        assign win_en[k]   = en_q;
        assign win_io[k]   = io_q;
        assign win_map[k]  = map_q;
    end

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        localparam logic [7:0] A = RGN_BASE_ADDR + 8'(2 * r);
        logic [AW-1:0] lo_q, hi_q;

        // Per-region inclusive boundary registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == A)        lo_q <= cfg_wdata[AW-1:0];
                if (cfg_addr == A + 8'd1) hi_q <= cfg_wdata[AW-1:0];
            end
        end

        assign rgn_lo[r] = lo_q;
        assign rgn_hi[r] = hi_q;
    end

endmodule

// File: rtl/ptd_bar_match.sv
// First decode stage: masked compare of the address against every window,
// gated by window enable, space type and command enable; lowest index wins.
// Assumes plain windows occupy indices below NBAR and swap windows above.
module ptd_bar_match #(
    parameter int AW     = 32,
    parameter int NBAR   = 2,
    parameter int BIDX_W = 2
) (
    input  logic                      addr_is_io,
    input  logic [AW-1:0]             addr,
    input  logic                      io_en,
    input  logic                      mem_en,
    input  logic [2*NBAR-1:0][AW-1:0] win_base,
    input  logic [2*NBAR-1:0][AW-1:0] win_mask,
    input  logic [2*NBAR-1:0]         win_en,
    input  logic [2*NBAR-1:0]         win_io,
    output logic                      claim,
    output logic                      swap,
    output logic [BIDX_W-1:0]         win_idx
);

    localparam int                NWIN       = 2 * NBAR;
    localparam logic [BIDX_W-1:0] FIRST_SWAP = BIDX_W'(NBAR);

    logic [NWIN-1:0] hit;
    logic            space_on;

    assign space_on = addr_is_io ? io_en : mem_en;

    for (genvar k = 0; k < NWIN; k++) begin : g_cmp
        assign hit[k] = win_en[k] && (win_io[k] == addr_is_io) &&
                        ((addr & win_mask[k]) == (win_base[k] & win_mask[k]));
    end

    // Priority pick of the lowest hitting window.
    always_comb begin
        win_idx = '0;
        for (int k = NWIN - 1; k >= 0; k--) begin
            if (hit[k]) win_idx = BIDX_W'(k);
        end
    end

    assign claim = space_on && (|hit);
    assign swap  = claim && (win_idx >= FIRST_SWAP);

endmodule

// File: rtl/ptd_range_sel.sv
// Second decode stage: inclusive low/high compare per region, filtered by
// the winning window's region map; lowest region index wins.
module ptd_range_sel #(
    parameter int AW     = 32,
    parameter int NREG   = 4,
    parameter int RIDX_W = 2
) (
    input  logic [AW-1:0]            addr,
    input  logic [NREG-1:0]          allow,
    input  logic [NREG-1:0][AW-1:0]  rgn_lo,
    input  logic [NREG-1:0][AW-1:0]  rgn_hi,
    output logic                     sub_hit,
    output logic [RIDX_W-1:0]        rgn_idx
);

    logic [NREG-1:0] in_rng;

    for (genvar r = 0; r < NREG; r++) begin : g_rng
        assign in_rng[r] = allow[r] && (addr >= rgn_lo[r]) && (addr <= rgn_hi[r]);
    end

    // Priority pick of the lowest matching region.
    always_comb begin
        rgn_idx = '0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (in_rng[r]) rgn_idx = RIDX_W'(r);
        end
    end

    assign sub_hit = |in_rng;

endmodule

// File: rtl/pci_tgt_decode.sv
// Two-stage PCI target address decoder. Each valid request is decoded
// combinationally and its result is registered, appearing one cycle later.
// A claimed request with no region match raises the sticky miss interrupt.
// Assumes AW <= 32, NBAR <= 4 and NREG <= 24.
module pci_tgt_decode
    import pci_tgt_decode_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NBAR   = 2,
    parameter int NREG   = 4,
    parameter int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_is_io,
    input  logic              req_write,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              o_valid,
    output logic              o_claim,
    output logic              o_swap,
    output logic              o_sub_hit,
    output logic [RIDX_W-1:0] o_region,
    output logic              o_fwd,
    output logic              o_write,
    output logic [3:0]        o_be,
    output logic [31:0]       o_data,
    output logic              o_miss_irq
);

    localparam int NWIN   = 2 * NBAR;
    localparam int BIDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

    logic                      io_en, mem_en;
    logic [NWIN-1:0][AW-1:0]   win_base, win_mask;
    logic [NWIN-1:0]           win_en, win_io;
    logic [NWIN-1:0][NREG-1:0] win_map;
    logic [NREG-1:0][AW-1:0]   rgn_lo, rgn_hi;

    logic                      claim_c, swap_c, sub_c;
    logic [BIDX_W-1:0]         win_idx;
    logic [RIDX_W-1:0]         rgn_c;
    logic                      miss_set;

    ptd_cfg_regs #(.AW(AW), .NBAR(NBAR), .NREG(NREG)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .miss_set (miss_set),
        .io_en    (io_en),
        .mem_en   (mem_en),
        .miss_irq (o_miss_irq),
        .win_base (win_base),
        .win_mask (win_mask),
        .win_en   (win_en),
        .win_io   (win_io),
        .win_map  (win_map),
        .rgn_lo   (rgn_lo),
        .rgn_hi   (rgn_hi)
    );

    ptd_bar_match #(.AW(AW), .NBAR(NBAR), .BIDX_W(BIDX_W)) u_bar (
        .addr_is_io(req_is_io),
        .addr      (req_addr),
        .io_en     (io_en),
        .mem_en    (mem_en),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_en    (win_en),
        .win_io    (win_io),
        .claim     (claim_c),
        .swap      (swap_c),
        .win_idx   (win_idx)
    );

    ptd_range_sel #(.AW(AW), .NREG(NREG), .RIDX_W(RIDX_W)) u_rng (
        .addr   (req_addr),
        .allow  (win_map[win_idx]),
        .rgn_lo (rgn_lo),
        .rgn_hi (rgn_hi),
        .sub_hit(sub_c),
        .rgn_idx(rgn_c)
    );

    assign miss_set = req_valid && claim_c && !sub_c;

    // Result register: decode outcome plus lane-adjusted data and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_claim   <= 1'b0;
            o_swap    <= 1'b0;
            o_sub_hit <= 1'b0;
            o_region  <= '0;
            o_fwd     <= 1'b0;
            o_write   <= 1'b0;
            o_be      <= '0;
            o_data    <= '0;
        end else begin
            o_valid   <= req_valid;
            o_claim   <= req_valid && claim_c;
            o_swap    <= req_valid && swap_c;
            o_sub_hit <= req_valid && claim_c && sub_c;
            o_region  <= (req_valid && claim_c && sub_c) ? rgn_c : '0;
            o_fwd     <= req_valid && claim_c && sub_c;
            o_write   <= req_valid && req_write;
            o_be      <= swap_c ? flip_be(req_be) : req_be;
            o_data    <= swap_c ? flip_word(req_wdata) : req_wdata;
        end
    end

endmodule

// File: rtl/pci_tgt_decode_chk.sv
// Temporal checks on the decoder ports, attached to every instance by bind.
module pci_tgt_decode_chk
    import pci_tgt_decode_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        req_valid,
    input logic [3:0]  req_be,
    input logic [31:0] req_wdata,
    input logic        o_valid,
    input logic        o_claim,
    input logic        o_swap,
    input logic        o_sub_hit,
    input logic        o_fwd,
    input logic [3:0]  o_be,
    input logic [31:0] o_data,
    input logic        o_miss_irq
);

    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_addr == CAUSE_ADDR) && cfg_wdata[MISS_BIT];

    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> o_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !o_valid);
    a_r6_fwd_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        o_fwd |-> (o_valid && o_claim && o_sub_hit));
    a_r3_swap_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
        o_swap |-> o_claim);
    a_r5_lanes_swapped: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_swap) |->
        (o_data == {$past(req_wdata[7:0]), $past(req_wdata[15:8]),
                    $past(req_wdata[23:16]), $past(req_wdata[31:24])}) &&
        (o_be == {$past(req_be[0]), $past(req_be[1]), $past(req_be[2]), $past(req_be[3])}));
    a_r5_lanes_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_swap) |-> (o_data == $past(req_wdata)) && (o_be == $past(req_be)));
    a_r7_miss_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_claim && !o_sub_hit) |-> o_miss_irq);
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (o_miss_irq && !clr_wr) |=> o_miss_irq);
    a_r7_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_miss_irq) |-> (o_valid && o_claim && !o_sub_hit));
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!o_valid && !o_miss_irq));

endmodule

bind pci_tgt_decode pci_tgt_decode_chk u_chk (.*);

// File: tb/tb_pci_tgt_decode.sv
module tb_pci_tgt_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        o_valid, o_claim, o_swap, o_sub_hit, o_fwd, o_write, o_miss_irq;
    logic [1:0]  o_region;
    logic [3:0]  o_be;
    logic [31:0] o_data;

    int total = 0;
    int bad   = 0;

    typedef struct packed {
        logic        claim;
        logic        swap;
        logic        sub;
        logic [1:0]  rgn;
        logic        fwd;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pci_tgt_decode dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_io(req_is_io), .req_write(req_write),
        .req_be(req_be), .req_wdata(req_wdata), .o_valid(o_valid), .o_claim(o_claim),
        .o_swap(o_swap), .o_sub_hit(o_sub_hit), .o_region(o_region), .o_fwd(o_fwd),
        .o_write(o_write), .o_be(o_be), .o_data(o_data), .o_miss_irq(o_miss_irq)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic c, s, h, input logic [1:0] r, input logic f, w,
                                input logic [3:0] be, input logic [31:0] d);
        return '{claim:c, swap:s, sub:h, rgn:r, fwd:f, wr:w, be:be, data:d};
    endfunction

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input logic io, wr, input logic [3:0] be,
                        input logic [31:0] d, input exp_t e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io; req_write = wr; req_be = be; req_wdata = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: every valid result is matched against the scoreboard head (R9).
    always @(negedge clk) begin
        if (rst_n && o_valid) begin
            exp_t  act;
            act = {o_claim, o_swap, o_sub_hit, o_region, o_fwd, o_write, o_be, o_data};
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", 64'(act), 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, 64'(act), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!o_valid && !o_claim && !o_miss_irq, "R10 reset state",
              64'({o_valid, o_claim, o_miss_irq}), 64'd0);
        // Unprogrammed windows claim nothing.
        send(32'h1000_0000, 1'b0, 1'b0, 4'hF, 32'h0102_0304,
             mk(0,0,0,2'd0,0,0,4'hF,32'h0102_0304), "R10 no claim before setup");

        // Setup (R11 address map).
        cfg_wr(8'h00, 32'h3);
        cfg_wr(8'h10, 32'h1000_0000); cfg_wr(8'h11, 32'hF000_0000); cfg_wr(8'h12, 32'h0301);
        cfg_wr(8'h14, 32'h0000_4000); cfg_wr(8'h15, 32'hFFFF_F000); cfg_wr(8'h16, 32'h0803);
        cfg_wr(8'h20, 32'h2000_0000); cfg_wr(8'h21, 32'hF000_0000); cfg_wr(8'h22, 32'h0401);
        cfg_wr(8'h24, 32'h1000_0000); cfg_wr(8'h25, 32'hF000_0000); cfg_wr(8'h26, 32'h0101);
        cfg_wr(8'h80, 32'h1000_0000); cfg_wr(8'h81, 32'h10FF_FFFF);
        cfg_wr(8'h82, 32'h1100_0000); cfg_wr(8'h83, 32'h11FF_FFFF);
        cfg_wr(8'h84, 32'h2000_0000); cfg_wr(8'h85, 32'h20FF_FFFF);
        cfg_wr(8'h86, 32'h0000_4000); cfg_wr(8'h87, 32'h0000_40FF);

        send(32'h1000_0010, 1'b0, 1'b0, 4'hF, 32'h1234_5678,
             mk(1,0,1,2'd0,1,0,4'hF,32'h1234_5678), "R3 plain beats swap, R4 region0");
        send(32'h1100_0020, 1'b0, 1'b1, 4'h3, 32'h1122_3344,
             mk(1,0,1,2'd1,1,1,4'h3,32'h1122_3344), "R4 region1 write, R5 passthrough");
        send(32'h2000_0004, 1'b0, 1'b1, 4'h1, 32'hAABB_CCDD,
             mk(1,1,1,2'd2,1,1,4'h8,32'hDDCC_BBAA), "R5 swap lanes, R3 swap window");
        send(32'h0000_4010, 1'b1, 1'b0, 4'hF, 32'h0,
             mk(1,0,1,2'd3,1,0,4'hF,32'h0), "R1 io window");
        send(32'h0000_4010, 1'b0, 1'b0, 4'hF, 32'h0,
             mk(0,0,0,2'd0,0,0,4'hF,32'h0), "R1 space mismatch");
        send(32'h3000_0000, 1'b0, 1'b0, 4'hF, 32'h5,
             mk(0,0,0,2'd0,0,0,4'hF,32'h5), "R1 mask compare miss");
        check(!o_miss_irq, "R7 unclaimed keeps irq low", 64'(o_miss_irq), 64'd0);

        send(32'h1200_0000, 1'b0, 1'b1, 4'hF, 32'hCAFE_0001,
             mk(1,0,0,2'd0,0,1,4'hF,32'hCAFE_0001), "R6 sub-decode miss drops write");
        check(o_miss_irq, "R7 irq set on miss", 64'(o_miss_irq), 64'd1);
        repeat (3) @(negedge clk);
        check(o_miss_irq, "R7 irq sticky", 64'(o_miss_irq), 64'd1);
        cfg_wr(8'h01, 32'h0);
        check(o_miss_irq, "R8 write zero keeps irq", 64'(o_miss_irq), 64'd1);
        cfg_wr(8'h01, 32'h2);
        check(!o_miss_irq, "R8 write one clears irq", 64'(o_miss_irq), 64'd0);

        // R2: memory space disabled, IO still enabled.
        cfg_wr(8'h00, 32'h1);
        send(32'h1000_0010, 1'b0, 1'b0, 4'hF, 32'h7,
             mk(0,0,0,2'd0,0,0,4'hF,32'h7), "R2 memory disabled");
        send(32'h0000_4020, 1'b1, 1'b1, 4'hF, 32'h8,
             mk(1,0,1,2'd3,1,1,4'hF,32'h8), "R2 io still enabled");
        send(32'h1200_0000, 1'b0, 1'b0, 4'hF, 32'h9,
             mk(0,0,0,2'd0,0,0,4'hF,32'h9), "R2 disabled miss not claimed");
        check(!o_miss_irq, "R7 disabled miss leaves irq", 64'(o_miss_irq), 64'd0);
        cfg_wr(8'h00, 32'h3);

        // R4: overlapping bounds, lowest region index wins.
        cfg_wr(8'h82, 32'h1000_0000);
        send(32'h1000_0010, 1'b0, 1'b0, 4'hF, 32'hA,
             mk(1,0,1,2'd0,1,0,4'hF,32'hA), "R4 overlap lowest region");
        send(32'h1180_0000, 1'b0, 1'b0, 4'hF, 32'hB,
             mk(1,0,1,2'd1,1,0,4'hF,32'hB), "R4 upper part region1");

        // R3/R1: disable plain window 0, swap window 1 takes over with map bit 0 only.
        cfg_wr(8'h12, 32'h0300);
        send(32'h1000_0010, 1'b0, 1'b1, 4'h6, 32'h0A0B_0C0D,
             mk(1,1,1,2'd0,1,1,4'h6,32'h0D0C_0B0A), "R3 swap window when plain disabled");
        send(32'h1100_0000, 1'b0, 1'b0, 4'h2, 32'h0A0B_0C0D,
             mk(1,1,0,2'd0,0,0,4'h4,32'h0D0C_0B0A), "R4 map excludes region1");
        check(o_miss_irq, "R7 miss via map", 64'(o_miss_irq), 64'd1);
        cfg_wr(8'h01, 32'h2);

        // R8: a miss and a clear in the same cycle; the miss wins.
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1200_0000; req_is_io = 1'b0; req_write = 1'b0;
        req_be = 4'hF; req_wdata = 32'h1;
        cfg_we = 1'b1; cfg_addr = 8'h01; cfg_wdata = 32'h2;
        exp_q.push_back(mk(1,1,0,2'd0,0,0,4'hF,32'h0100_0000));
        tag_q.push_back("R8 simultaneous miss result");
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check(o_miss_irq, "R8 set wins over clear", 64'(o_miss_irq), 64'd1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 every request answered", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule